// File: doc/BRIEF.md
# Real-Time Clock Tick and Interrupt Status Unit

This unit turns a slow reference clock, presented as a one-cycle enable strobe inside the bus clock domain, into a family of periodic tick events: once per second, and at every power of two from 2 Hz up to 512 Hz. A fractional accumulator divides the reference down to an internal 1024 Hz base rate. This means that reference rates of 32000 Hz and 38400 Hz, which are not powers of two, still give ticks whose long-term average rate is exact. A binary counter then halves the base rate repeatedly.

Every tick is captured in a sticky status register, together with two single-cycle events from neighbouring logic: an alarm match and a stopwatch expiry. Software clears status bits by writing ones to them. An enable register selects which captured events raise the single interrupt line.

Software reaches the status, enable and clock-select registers through a minimal register bus. A write is a one-cycle strobe with an address and data. Read data follows the address combinationally.

Top module: `rtc_tick_irq`

## Requirements
- R1: The status and enable registers share one bit layout: bit 0 stopwatch, bit 2 alarm, bit 4 one-second tick, bit 7 the 2 Hz tick, and bits 8 to 15 the 4, 8, 16, 32, 64, 128, 256 and 512 Hz ticks in ascending order. All other bits always read 0, so writing 16'hFFFF to the enable register reads back 16'hFF95.
- R2: Clock-select code 0 assumes a 32768 Hz reference, code 1 assumes 32000 Hz and code 2 assumes 38400 Hz. The tick of rate r fires once for every ref/r reference strobes on long-term average. The one-second bit first sets after exactly ref strobes following reset. Code 3 stops all periodic ticks.
- R3: A periodic status bit becomes visible after the third rising edge, counting the edge that samples the completing reference strobe as the first. An alarm or stopwatch event is visible right after the edge that samples it.
- R4: A status bit stays set until software clears it, whether or not its enable bit is set.
- R5: A write to address 0 clears exactly those status bits whose data bit is 1. Zero data bits leave their bits unchanged, and 16'hFFFF clears every bit.
- R6: If an event and a clearing write reach the same status bit on the same edge, the bit ends up set.
- R7: The interrupt output is high exactly when some status bit and its enable bit are both 1. It changes in the same cycle as the register that causes the change.
- R8: The enable register sits at address 1 and can be read and written. Writing 0 to it holds the interrupt low while status bits keep latching.
- R9: Address 2 holds the 2-bit clock-select code in bits 1:0 and reads it back with all upper bits 0. Address 3 reads 0.
- R10: After reset, status, enable and clock select are all 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe per reference clock period |
| alarm_evt | input | 1 | Alarm match event, one cycle |
| swatch_evt | input | 1 | Stopwatch expiry event, one cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 status, 1 enable, 2 clock select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Interrupt request, active high |

## Verification
Results arrive at different delays. Register writes and external events show in the registers right after the edge that samples them. A periodic tick needs two more edges to pass through the divider and counter stages. The interrupt and read data follow the registers combinationally within the same cycle. The bench's behavioural model advances on each rising edge using the inputs held since the previous one, and it compares read data and the interrupt at every falling edge. Directed checks read the registers one time unit after the edge they target, and they count edges explicitly when probing the two-cycle pipeline delay of a tick.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

   localparam int STAT_W   = 16;
   localparam int ADDR_W   = 2;
   localparam int N_SAMPLE = 8;
   localparam int N_TICKS  = N_SAMPLE + 2;

   localparam int POS_SWATCH  = 0;
   localparam int POS_ALARM   = 2;
   localparam int POS_SECOND  = 4;
   localparam int POS_HALF    = 7;
   localparam int POS_SAMPLE0 = 8;

   localparam logic [STAT_W-1:0] STAT_VALID =
      (STAT_W'(1) << POS_SWATCH) | (STAT_W'(1) << POS_ALARM) |
      (STAT_W'(1) << POS_SECOND) | (STAT_W'(1) << POS_HALF)  |
      (((STAT_W'(1) << N_SAMPLE) - STAT_W'(1)) << POS_SAMPLE0);

   typedef enum logic [1:0] {
      REF_SEL_A   = 2'd0,
      REF_SEL_B   = 2'd1,
      REF_SEL_C   = 2'd2,
      REF_SEL_OFF = 2'd3
   } ref_sel_e;

   typedef enum logic [ADDR_W-1:0] {
      REG_STATUS = 2'd0,
      REG_ENABLE = 2'd1,
      REG_CLKSEL = 2'd2,
      REG_SPARE  = 2'd3
   } reg_addr_e;

   // Tick vector index i carries rate BASE/2^(i+1); map it to its status bit.
   function automatic int tick_pos(input int i);
      if (i < N_SAMPLE)       return POS_SAMPLE0 + (N_SAMPLE - 1 - i);
      else if (i == N_SAMPLE) return POS_HALF;
      else                    return POS_SECOND;
   endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
   parameter int REF0_HZ = 32768,
   parameter int REF1_HZ = 32000,
   parameter int REF2_HZ = 38400,
   parameter int BASE_HZ = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_stb,
   input  logic [1:0] sel,
   output logic       base_stb
);

   localparam int MAX01  = (REF0_HZ > REF1_HZ) ? REF0_HZ : REF1_HZ;
   localparam int MAX_HZ = (MAX01 > REF2_HZ) ? MAX01 : REF2_HZ;
   localparam int ACC_W  = $clog2(MAX_HZ + BASE_HZ) + 1;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] rate;
   logic [ACC_W-1:0] sum;
   logic             run;
   logic             wrap;

   always_comb begin
      run = 1'b1;
      case (sel)
         2'd0:    rate = ACC_W'(REF0_HZ);
         2'd1:    rate = ACC_W'(REF1_HZ);
         2'd2:    rate = ACC_W'(REF2_HZ);
         default: begin
            rate = ACC_W'(REF0_HZ);
            run  = 1'b0;
         end
      endcase
      sum  = acc_q + ACC_W'(BASE_HZ);
      wrap = (sum >= rate);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         base_stb <= 1'b0;
      end else if (ref_stb && run) begin
         acc_q    <= wrap ? (sum - rate) : sum;
         base_stb <= wrap;
      end else begin
         base_stb <= 1'b0;
      end
   end

endmodule

// File: rtl/rtc_tick_chain.sv
module rtc_tick_chain #(
   parameter int N_TICKS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               base_stb,
   output logic [N_TICKS-1:0] tick
);

   logic [N_TICKS-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (base_stb) cnt_q <= cnt_q + N_TICKS'(1);
   end

   for (genvar i = 0; i < N_TICKS; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick[i] <= 1'b0;
         else        tick[i] <= base_stb && (&cnt_q[i:0]);
      end
   end

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
   import rtc_tick_pkg::*;
#(
   parameter int NT = N_TICKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NT-1:0]     tick,
   input  logic              alarm_evt,
   input  logic              swatch_evt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [STAT_W-1:0] bus_wdata,
   output logic [STAT_W-1:0] bus_rdata,
   output logic [STAT_W-1:0] stat,
   output logic [STAT_W-1:0] en,
   output logic [1:0]        sel,
   output logic              irq
);

   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic              wr_stat;
   logic              wr_en;
   logic              wr_sel;

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < NT; i++) begin
         if (tick[i]) set_vec[tick_pos(i)] = 1'b1;
      end
      set_vec[POS_ALARM]  = set_vec[POS_ALARM]  | alarm_evt;
      set_vec[POS_SWATCH] = set_vec[POS_SWATCH] | swatch_evt;
   end

   assign wr_stat = bus_wr && (reg_addr_e'(bus_addr) == REG_STATUS);
   assign wr_en   = bus_wr && (reg_addr_e'(bus_addr) == REG_ENABLE);
   assign wr_sel  = bus_wr && (reg_addr_e'(bus_addr) == REG_CLKSEL);
   assign clr_vec = wr_stat ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
         sel  <= REF_SEL_A;
      end else begin
         stat <= ((stat & ~clr_vec) | set_vec) & STAT_VALID;
         if (wr_en)  en  <= bus_wdata & STAT_VALID;
         if (wr_sel) sel <= bus_wdata[1:0];
      end
   end

   always_comb begin
      case (reg_addr_e'(bus_addr))
         REG_STATUS: bus_rdata = stat;
         REG_ENABLE: bus_rdata = en;
         REG_CLKSEL: bus_rdata = {{(STAT_W-2){1'b0}}, sel};
         default:    bus_rdata = '0;
      endcase
   end

   assign irq = |(stat & en);

endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
   import rtc_tick_pkg::*;
#(
   parameter int REF0_HZ = 32768,
   parameter int REF1_HZ = 32000,
   parameter int REF2_HZ = 38400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_stb,
   input  logic              alarm_evt,
   input  logic              swatch_evt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [STAT_W-1:0] bus_wdata,
   output logic [STAT_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int BASE_HZ = 1 << N_TICKS;

   if (REF0_HZ < BASE_HZ || REF1_HZ < BASE_HZ || REF2_HZ < BASE_HZ) begin : g_bad_ref
      $error("reference rates must be at least the base tick rate");
   end
   if (STAT_W != 16 || ADDR_W != 2) begin : g_bad_map
      $error("register layout assumes 16 data bits and 2 address bits");
   end

   logic              base_w;
   logic [N_TICKS-1:0] tick_w;
   logic [STAT_W-1:0] stat_w;
   logic [STAT_W-1:0] en_w;
   logic [1:0]        sel_w;

   rtc_tick_divider #(
      .REF0_HZ(REF0_HZ),
      .REF1_HZ(REF1_HZ),
      .REF2_HZ(REF2_HZ),
      .BASE_HZ(BASE_HZ)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_stb (ref_stb),
      .sel     (sel_w),
      .base_stb(base_w)
   );

   rtc_tick_chain #(
      .N_TICKS(N_TICKS)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_stb(base_w),
      .tick    (tick_w)
   );

   rtc_irq_regs #(
      .NT(N_TICKS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_w),
      .alarm_evt (alarm_evt),
      .swatch_evt(swatch_evt),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .stat      (stat_w),
      .en        (en_w),
      .sel       (sel_w),
      .irq       (irq)
   );

endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk
   import rtc_tick_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               irq,
   input logic [STAT_W-1:0]  stat,
   input logic [STAT_W-1:0]  en,
   input logic [1:0]         sel,
   input logic               base_stb,
   input logic [N_TICKS-1:0] ticks,
   input logic               alarm_evt,
   input logic               alarm_clr_wr
);

   // R6: an alarm event wins over a clear on the same edge
   a_r6_alarm_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> stat[POS_ALARM]);

   // R4: the alarm bit holds until a write clears it
   a_r4_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[POS_ALARM] && !alarm_clr_wr) |=> stat[POS_ALARM]);

   // R8: with nothing enabled the interrupt stays low
   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

   // R7: an interrupt needs a pending status bit
   a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat != '0));

   // R2: select code 3 produces no base strobes
   a_r2_off_no_base: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd3 && $past(sel) == 2'd3) |-> !base_stb);

   // R3: every tick follows a base strobe one cycle earlier
   a_r3_tick_after_base: assert property (@(posedge clk) disable iff (!rst_n)
      (|ticks) |-> $past(base_stb));

endmodule

bind rtc_tick_irq rtc_tick_irq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq         (irq),
   .stat        (stat_w),
   .en          (en_w),
   .sel         (sel_w),
   .base_stb    (base_w),
   .ticks       (tick_w),
   .alarm_evt   (alarm_evt),
   .alarm_clr_wr(bus_wr && (bus_addr == 2'd0) && bus_wdata[2])
);

// File: tb/rtc_tick_irq_tb.sv
`timescale 1ns/1ps
module rtc_tick_irq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_stb = 1'b0;
   logic        alarm_evt = 1'b0;
   logic        swatch_evt = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        irq;

   int errs = 0;
   int checks = 0;
   bit running = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rtc_tick_irq dut_i (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .alarm_evt(alarm_evt),
      .swatch_evt(swatch_evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   int          m_acc, m_nbase;
   logic        m_base;
   logic [9:0]  m_tick;
   logic [15:0] m_stat, m_en;
   logic [1:0]  m_sel;
   localparam logic [15:0] VALID = 16'hFF95;

   function automatic int rate_of(input logic [1:0] s);
      case (s)
         2'd0: return 32768;
         2'd1: return 32000;
         2'd2: return 38400;
         default: return 0;
      endcase
   endfunction

   // R1 layout: tick of 2^(i+1)-fold division of 1024 Hz
   function automatic int bit_of(input int i);
      if (i < 8) return 15 - i;
      if (i == 8) return 7;
      return 4;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      logic [15:0] set_v, clr_v;
      logic [9:0]  nt;
      logic        nb;
      if (!rst_n) begin
         m_acc = 0; m_nbase = 0; m_base = 0; m_tick = '0;
         m_stat = '0; m_en = '0; m_sel = '0;
      end else begin
         set_v = '0;
         for (int i = 0; i < 10; i++) if (m_tick[i]) set_v[bit_of(i)] = 1'b1;
         if (alarm_evt)  set_v[2] = 1'b1;
         if (swatch_evt) set_v[0] = 1'b1;
         clr_v = (bus_wr && bus_addr == 2'd0) ? bus_wdata : 16'h0;
         nt = '0;
         if (m_base) begin
            m_nbase++;
            for (int i = 0; i < 10; i++) if ((m_nbase % (2 ** (i + 1))) == 0) nt[i] = 1'b1;
         end
         nb = 1'b0;
         if (ref_stb && m_sel != 2'd3) begin
            m_acc += 1024;
            if (m_acc >= rate_of(m_sel)) begin
               m_acc -= rate_of(m_sel);
               nb = 1'b1;
            end
         end
         m_stat = ((m_stat & ~clr_v) | set_v) & VALID;
         if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata & VALID;
         if (bus_wr && bus_addr == 2'd2) m_sel = bus_wdata[1:0];
         m_tick = nt;
         m_base = nb;
      end
   end

   // every-clock comparison, away from the active edge
   always @(negedge clk) begin
      logic [15:0] exp_rd;
      if (running && rst_n && !done) begin
         case (bus_addr)
            2'd0: exp_rd = m_stat;
            2'd1: exp_rd = m_en;
            2'd2: exp_rd = {14'h0, m_sel};
            default: exp_rd = 16'h0;
         endcase
         checks++;
         if (bus_rdata !== exp_rd) begin
            errs++;
            $display("FAIL R2 R3 R9 model rdata addr=%0d actual=%h expected=%h", bus_addr, bus_rdata, exp_rd);
         end
         checks++;
         if (irq !== |(m_stat & m_en)) begin
            errs++;
            $display("FAIL R7 model irq actual=%b expected=%b", irq, |(m_stat & m_en));
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 1'b0; bus_wdata = 16'h0;
   endtask

   task automatic do_reset();
      ref_stb = 0; alarm_evt = 0; swatch_evt = 0; bus_wr = 0;
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic run_stb(input int n);
      ref_stb = 1'b1;
      for (int k = 0; k < n; k++) begin
         bus_addr = k[1:0];
         step();
      end
      ref_stb = 1'b0;
   endtask

   task automatic second_run(input logic [1:0] s, input int refs);
      logic [15:0] v;
      do_reset();
      wr(2'd2, {14'h0, s});
      run_stb(refs - 100);
      repeat (2) step();
      rd(2'd0, v);
      chk($sformatf("R2 sel=%0d one-second bit before period", s), v & 16'h0010, 16'h0000);
      run_stb(100);
      repeat (2) step();
      rd(2'd0, v);
      chk($sformatf("R2 sel=%0d one-second bit after period", s), v & 16'h0010, 16'h0010);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [15:0] v;
      do_reset();
      running = 1;

      // R10 reset state
      rd(2'd0, v); chk("R10 status after reset", v, 16'h0);
      rd(2'd1, v); chk("R10 enable after reset", v, 16'h0);
      rd(2'd2, v); chk("R10 clksel after reset", v, 16'h0);
      chk("R10 irq after reset", {15'h0, irq}, 16'h0);

      // R3 / R7 external event visible after its edge
      wr(2'd1, 16'h0004);
      alarm_evt = 1'b1; step(); alarm_evt = 1'b0;
      rd(2'd0, v); chk("R3 alarm latched after its edge", v, 16'h0004);
      chk("R7 irq with enabled alarm", {15'h0, irq}, 16'h1);

      // R6 set wins over same-edge clear
      alarm_evt = 1'b1; wr(2'd0, 16'h0004); alarm_evt = 1'b0;
      rd(2'd0, v); chk("R6 set beats clear", v, 16'h0004);

      // R5 zero bits do nothing, one bits clear
      wr(2'd0, 16'h0000);
      rd(2'd0, v); chk("R5 zero write keeps bits", v, 16'h0004);
      wr(2'd0, 16'h0004);
      rd(2'd0, v); chk("R5 one write clears bit", v, 16'h0000);
      chk("R7 irq drops with status", {15'h0, irq}, 16'h0);

      // R8 / R4 disabled source still latches and holds
      wr(2'd1, 16'h0000);
      swatch_evt = 1'b1; step(); swatch_evt = 1'b0;
      rd(2'd0, v); chk("R4 stopwatch latches while disabled", v, 16'h0001);
      chk("R8 irq low with enable zero", {15'h0, irq}, 16'h0);
      repeat (5) step();
      rd(2'd0, v); chk("R4 stopwatch bit still pending", v, 16'h0001);
      wr(2'd1, 16'h0001);
      chk("R7 irq rises on enable write", {15'h0, irq}, 16'h1);
      wr(2'd0, 16'hFFFF);
      rd(2'd0, v); chk("R5 all-ones clears all", v, 16'h0000);

      // R1 / R8 / R9 register widths
      wr(2'd1, 16'hFFFF);
      rd(2'd1, v); chk("R1 enable keeps only defined bits", v, 16'hFF95);
      wr(2'd2, 16'hFFFF);
      rd(2'd2, v); chk("R9 clksel reads two bits", v, 16'h0003);
      rd(2'd3, v); chk("R9 spare address reads zero", v, 16'h0000);
      wr(2'd2, 16'h0000);
      rd(2'd2, v); chk("R9 clksel back to zero", v, 16'h0000);

      // R3 periodic latency: 64th strobe completes the first 512 Hz tick
      do_reset();
      run_stb(63);
      repeat (4) step();
      rd(2'd0, v); chk("R3 no tick before 64 strobes", v, 16'h0000);
      ref_stb = 1'b1; step(); ref_stb = 1'b0;
      rd(2'd0, v); chk("R3 tick absent after first edge", v, 16'h0000);
      step();
      rd(2'd0, v); chk("R3 tick absent after second edge", v, 16'h0000);
      step();
      rd(2'd0, v); chk("R3 512 Hz bit after third edge", v, 16'h8000);

      // R2 one-second period for each reference
      second_run(2'd0, 32768);
      second_run(2'd1, 32000);
      second_run(2'd2, 38400);

      // R2 select code 3 stops ticks
      do_reset();
      wr(2'd2, 16'h0003);
      run_stb(3000);
      repeat (3) step();
      rd(2'd0, v); chk("R2 no ticks with code 3", v, 16'h0000);

      // sparse strobes, mixed events and clears, checked by the model
      do_reset();
      wr(2'd2, 16'h0001);
      wr(2'd1, 16'hF0F5);
      for (int k = 0; k < 6000; k++) begin
         ref_stb    = (k % 3 == 0);
         alarm_evt  = (k % 97 == 5);
         swatch_evt = (k % 131 == 7);
         bus_wr     = (k % 500 == 250);
         bus_wdata  = 16'hAAAA;
         bus_addr   = bus_wr ? 2'd0 : k[1:0];
         step();
      end
      ref_stb = 0; alarm_evt = 0; swatch_evt = 0; bus_wr = 0; bus_wdata = 0;
      step();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule